// File: doc/BRIEF.md
# Byte SPI Master with Start/Load/Done Handshake

This block is a memory-mapped SPI master that moves one byte per transfer. Software sees two 8-bit registers: a data register and a control register. To run a transfer, software first writes the byte into the data register. It then sets the start bit in the control register. The block copies the data register into its shift register and clears its bit counter. It then clocks eight bits on the serial lines and raises a done flag when it finishes.

Three flags carry the handshake: start, load and done. A direction bit selects a write access or a read access. In a write access the outgoing byte leaves the data register unchanged. In a read access the byte captured from MISO replaces the data register contents. Two chip-select outputs, one for a touch controller and one for a codec, are set directly by software through the control register.

The serial clock runs at the system clock divided by `CLK_DIV`, which must be even and at least 2. It uses SPI mode 0: the clock idles low, MISO is sampled on the rising edge and MOSI changes on the falling edge.

Top module: `spi_hs_master`

## Requirements
- R1: After reset both registers read 0x00, SCLK is low and both chip selects are low.
- R2: `regAddr`=0 addresses the data register and `regAddr`=1 addresses the control register. Control bit layout: bits 7:6 always read 0; bit 5 is the load flag; bit 4 is the start flag; bit 3 is the done flag; bit 2 is direction (1 = read access); bit 1 is the touch chip select; bit 0 is the codec chip select.
- R3: A control write with bit 4 = 1 while idle starts a transfer. In the cycle after that write, start reads 1 and done and load read 0. One cycle later load reads 1, which shows that the data register has been copied and the bit count cleared.
- R4: A transfer gives exactly 8 rising SCLK edges with period `CLK_DIV` clocks, MSB first, in mode 0. SCLK is low whenever no transfer runs.
- R5: In a write access the data register is shifted out on MOSI, MISO is ignored and the data register keeps its value.
- R6: In a read access the 8 bits sampled on MISO replace the data register, with the first sampled bit ending up as the MSB.
- R7: Done becomes 1 and start becomes 0 on the clock edge 8*`CLK_DIV`+1 cycles after the edge that accepted the start. Load stays 1 after the transfer.
- R8: While a transfer runs, a control write with start = 1 does not restart the transfer or change its length. Writes to the direction bit and to the data register are also ignored during that time.
- R9: The chip-select outputs follow control bits 1 and 0 and are active high. They are writable at any time, including during a transfer.
- R10: A control write with bit 4 = 0 while idle starts no transfer. Done and load keep their values and SCLK does not toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 data, 1 control |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data of the addressed register (combinational) |
| sclk | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csTouch | output | 1 | Touch controller select, active high |
| csCodec | output | 1 | Codec select, active high |

## Verification
Two things can happen in the same cycle: the shift engine is busy with a transfer while software writes the control and data registers. The bench provokes this with a second start request during a transfer. That request also flips the direction bit and rewrites the data byte. The bench passes only if the transfer still ends on its original cycle count, the direction bit reads back unchanged, and the data register keeps the byte that was being sent. During another transfer the bench also changes a chip select and checks that the pin follows the write at once.

// File: rtl/spi_hs_pkg.sv
package spi_hs_pkg;

  localparam int unsigned REG_W = 8;

  // control register field positions
  localparam int unsigned CB_LOAD  = 5;
  localparam int unsigned CB_START = 4;
  localparam int unsigned CB_DONE  = 3;
  localparam int unsigned CB_DIR   = 2;
  localparam int unsigned CB_CST   = 1;
  localparam int unsigned CB_CSC   = 0;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_SHIFT = 2'd2
  } spiState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // copy data register into shift register
    logic sample;   // capture MISO (rising SCLK)
    logic shift;    // advance shift register (falling SCLK)
    logic finish;   // last shift of the frame
    logic readDir;  // active access is a read
    logic idle;     // no transfer running
  } dpStrobe_t;

endpackage

// File: rtl/spi_hs_ctrl.sv
module spi_hs_ctrl
  import spi_hs_pkg::*;
#(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctrlWr,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] ctrlRd,
  output dpStrobe_t        strobe,
  output logic             sclk,
  output logic             csTouch,
  output logic             csCodec
);

  localparam int unsigned HALF  = CLK_DIV / 2;
  localparam int unsigned DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int unsigned BIT_W = $clog2(REG_W);

  spiState_t        state;
  logic [DIV_W-1:0] divCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             startFlag, loadFlag, doneFlag, dirRead;
  logic             startReq, divWrap;

  assign startReq = ctrlWr && wrData[CB_START] && (state == ST_IDLE);
  assign divWrap  = (divCnt == DIV_W'(CLK_DIV - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      divCnt    <= '0;
      bitCnt    <= '0;
      startFlag <= 1'b0;
      loadFlag  <= 1'b0;
      doneFlag  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startReq) begin
            state     <= ST_LOAD;
            startFlag <= 1'b1;
            loadFlag  <= 1'b0;
            doneFlag  <= 1'b0;
          end
        end
        ST_LOAD: begin
          state    <= ST_SHIFT;
          loadFlag <= 1'b1;
          divCnt   <= '0;
          bitCnt   <= '0;
        end
        ST_SHIFT: begin
          if (divWrap) begin
            divCnt <= '0;
            if (bitCnt == BIT_W'(REG_W - 1)) begin
              state     <= ST_IDLE;
              doneFlag  <= 1'b1;
              startFlag <= 1'b0;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // software-owned bits: selects any time, direction only while idle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csTouch <= 1'b0;
      csCodec <= 1'b0;
      dirRead <= 1'b0;
    end else if (ctrlWr) begin
      csTouch <= wrData[CB_CST];
      csCodec <= wrData[CB_CSC];
      if (state == ST_IDLE) dirRead <= wrData[CB_DIR];
    end
  end

  assign sclk = (state == ST_SHIFT) && (divCnt >= DIV_W'(HALF));

  always_comb begin
    strobe.load    = (state == ST_LOAD);
    strobe.sample  = (state == ST_SHIFT) && (divCnt == DIV_W'(HALF - 1));
    strobe.shift   = (state == ST_SHIFT) && divWrap;
    strobe.finish  = strobe.shift && (bitCnt == BIT_W'(REG_W - 1));
    strobe.readDir = dirRead;
    strobe.idle    = (state == ST_IDLE);
  end

  always_comb begin
    ctrlRd           = '0;
    ctrlRd[CB_LOAD]  = loadFlag;
    ctrlRd[CB_START] = startFlag;
    ctrlRd[CB_DONE]  = doneFlag;
    ctrlRd[CB_DIR]   = dirRead;
    ctrlRd[CB_CST]   = csTouch;
    ctrlRd[CB_CSC]   = csCodec;
  end

  // R3: an accepted start clears done and raises start
  p_start_accept_r3: assert property (@(posedge clk) disable iff (!rstN)
    startReq |=> (!doneFlag && startFlag));

  // R3: load flag follows the load step
  p_load_flag_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOAD) |=> loadFlag);

  // R4: clock parked low while done is showing
  p_sclk_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag |-> !sclk);

  // R4: sample and shift never coincide
  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.sample, strobe.shift, strobe.load}));

  // R8: start request during shifting does not reload
  p_busy_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SHIFT && ctrlWr) |=> (state != ST_LOAD));

  // R8: direction frozen while busy
  p_dir_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |=> $stable(dirRead));

endmodule

// File: rtl/spi_hs_datapath.sv
module spi_hs_datapath
  import spi_hs_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             dataWr,
  input  logic [REG_W-1:0] wrData,
  input  dpStrobe_t        strobe,
  input  logic             miso,
  output logic             mosi,
  output logic [REG_W-1:0] dataRd
);

  logic [REG_W-1:0] dataReg, shiftReg;
  logic             rxBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg  <= '0;
      shiftReg <= '0;
      rxBit    <= 1'b0;
    end else begin
      if (dataWr && strobe.idle) dataReg <= wrData;
      if (strobe.load)   shiftReg <= dataReg;
      if (strobe.sample) rxBit    <= miso;
      if (strobe.shift)  shiftReg <= {shiftReg[REG_W-2:0], rxBit};
      if (strobe.finish && strobe.readDir)
        dataReg <= {shiftReg[REG_W-2:0], rxBit};
    end
  end

  assign mosi   = shiftReg[REG_W-1];
  assign dataRd = dataReg;

  // R5: a write access leaves the data register alone
  p_write_keeps_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finish && !strobe.readDir) |=> $stable(dataReg));

  // R8: data writes while busy are dropped
  p_busy_data_r8: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && !strobe.idle && !strobe.finish) |=> $stable(dataReg));

endmodule

// File: rtl/spi_hs_master.sv
module spi_hs_master
  import spi_hs_pkg::*;
#(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       regAddr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso,
  output logic       csTouch,
  output logic       csCodec
);

  dpStrobe_t        strobe;
  logic [REG_W-1:0] ctrlRd, dataRd;

  spi_hs_ctrl #(.CLK_DIV(CLK_DIV)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .ctrlWr  (wrEn && regAddr),
    .wrData  (wrData),
    .ctrlRd  (ctrlRd),
    .strobe  (strobe),
    .sclk    (sclk),
    .csTouch (csTouch),
    .csCodec (csCodec)
  );

  spi_hs_datapath uData (
    .clk    (clk),
    .rstN   (rstN),
    .dataWr (wrEn && !regAddr),
    .wrData (wrData),
    .strobe (strobe),
    .miso   (miso),
    .mosi   (mosi),
    .dataRd (dataRd)
  );

  assign rdData = regAddr ? ctrlRd : dataRd;

endmodule

// File: tb/sim_spi_hs_master.sv
module sim_spi_hs_master;

  localparam int DIV = 4;
  localparam int XFER_CYC = 8 * DIV + 2;

  // {dir, txByte, slaveByte}
  localparam logic [16:0] VEC [6] = '{
    {1'b0, 8'hA5, 8'h3C},
    {1'b1, 8'h00, 8'hC3},
    {1'b1, 8'hFF, 8'h01},
    {1'b0, 8'h80, 8'hFF},
    {1'b1, 8'h96, 8'h80},
    {1'b0, 8'h01, 8'h00}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       regAddr = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       sclk, mosi, miso, csTouch, csCodec;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  spi_hs_master #(.CLK_DIV(DIV)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .sclk(sclk), .mosi(mosi), .miso(miso),
    .csTouch(csTouch), .csCodec(csCodec)
  );

  // mode-0 slave model
  logic [7:0] slaveTx = '0;
  logic [7:0] slaveRx = '0;
  int riseCnt = 0;
  assign miso = slaveTx[7];
  always @(posedge sclk) begin
    slaveRx <= {slaveRx[6:0], mosi};
    riseCnt <= riseCnt + 1;
  end
  always @(negedge sclk) slaveTx <= {slaveTx[6:0], 1'b0};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdReg(input logic a, output logic [7:0] v);
    regAddr = a;
    #1;
    v = rdData;
  endtask

  task automatic xfer(input logic dir, input logic [7:0] tx, input logic [7:0] sl);
    logic [7:0] v;
    int cnt;
    wrReg(1'b0, tx);
    slaveTx = sl;
    riseCnt = 0;
    wrReg(1'b1, {3'b000, 1'b1, 1'b0, dir, 2'b00});
    rdReg(1'b1, v);
    chk(v == (8'h10 | {5'd0, dir, 2'd0}), "R3 flags after accept", v, 8'h10 | {5'd0, dir, 2'd0});
    @(negedge clk);
    cnt = 2;
    rdReg(1'b1, v);
    chk(v[5] == 1'b1, "R3 load flag", v, 8'h20);
    while (!v[3] && cnt < 2000) begin
      @(negedge clk);
      cnt++;
      rdReg(1'b1, v);
    end
    chk(cnt == XFER_CYC, "R7 done timing", cnt, XFER_CYC);
    chk(v == (8'h28 | {5'd0, dir, 2'd0}), "R7 flags at done", v, 8'h28 | {5'd0, dir, 2'd0});
    chk(riseCnt == 8, "R4 sclk rising edges", riseCnt, 8);
    chk(sclk == 1'b0, "R4 sclk idle low", sclk, 0);
    chk(slaveRx == tx, "R4 MSB-first MOSI", slaveRx, tx);
    rdReg(1'b0, v);
    if (dir) chk(v == sl, "R6 read replaces data", v, sl);
    else     chk(v == tx, "R5 write keeps data", v, tx);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int cnt;
    repeat (3) @(negedge clk);
    // R1 reset state
    rdReg(1'b0, v); chk(v == 8'h00, "R1 data reset", v, 0);
    rdReg(1'b1, v); chk(v == 8'h00, "R1 ctrl reset", v, 0);
    chk({sclk, csTouch, csCodec} == 3'b000, "R1 pins reset", {sclk, csTouch, csCodec}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2/R9/R10: unused bits, selects, no transfer without start
    wrReg(1'b1, 8'hC3);
    riseCnt = 0;
    rdReg(1'b1, v); chk(v == 8'h03, "R2 unused bits read 0", v, 8'h03);
    chk({csTouch, csCodec} == 2'b11, "R9 selects high", {csTouch, csCodec}, 3);
    repeat (3 * DIV) @(negedge clk);
    rdReg(1'b1, v); chk(v == 8'h03, "R10 no start no flags", v, 8'h03);
    chk(riseCnt == 0, "R10 no sclk", riseCnt, 0);
    wrReg(1'b1, 8'h02);
    chk({csTouch, csCodec} == 2'b10, "R9 touch only", {csTouch, csCodec}, 2);
    wrReg(1'b1, 8'h00);

    // table walk: R3..R7
    foreach (VEC[i]) xfer(VEC[i][16], VEC[i][15:8], VEC[i][7:0]);

    // R10 after a transfer: done and load are kept
    wrReg(1'b1, 8'h00);
    rdReg(1'b1, v); chk(v == 8'h28, "R10 flags kept", v, 8'h28);

    // R8/R9: writes during a transfer
    wrReg(1'b0, 8'h5A);
    slaveTx = 8'hE7;
    riseCnt = 0;
    wrReg(1'b1, 8'h10);
    cnt = 1;
    repeat (5) begin @(negedge clk); cnt++; end
    regAddr = 1'b1; wrData = 8'h16; wrEn = 1'b1;  // start+read+touch
    @(negedge clk); cnt++;
    regAddr = 1'b0; wrData = 8'hFF;                // data write while busy
    @(negedge clk); cnt++;
    wrEn = 1'b0;
    chk(csTouch == 1'b1, "R9 select writable when busy", csTouch, 1);
    rdReg(1'b1, v);
    while (!v[3] && cnt < 2000) begin
      @(negedge clk);
      cnt++;
      rdReg(1'b1, v);
    end
    chk(cnt == XFER_CYC, "R8 restart ignored", cnt, XFER_CYC);
    chk(v == 8'h2A, "R8 direction frozen", v, 8'h2A);
    rdReg(1'b0, v); chk(v == 8'h5A, "R8 data write ignored", v, 8'h5A);
    chk(slaveRx == 8'h5A, "R8 byte sent intact", slaveRx, 8'h5A);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule